// File: doc/BRIEF.md
# Tiled INT8 Matrix-Multiply Core

This core multiplies signed 8-bit operand tiles and returns signed 32-bit results. Software loads four run-time values: the M row count, the N column count, the number of 8-deep reduction steps (K/8), and how many N tiles belong to this core. It then pulses a start input. The core walks the whole job as a sequence of 16x16 output blocks.

For each block the core zeroes four resident 8x8 accumulators. It then takes one A beat (a 16x8 slice) and one B beat (an 8x16 slice) per reduction step. Each step issues four 8x8x8 multiply-accumulates, one per quadrant of the block, that add into those accumulators. When the last reduction step of the block is in, the 16 result rows are streamed out one row per beat. After the final row of the final block, a done pulse is raised.

Configurations that cannot be tiled are refused with a one-cycle error pulse, and no operand is taken.

Top module: `mm_tile_core`

## Requirements
- R1: After reset, busy_o, done_o, err_o, c_valid_o, a_ready_o and b_ready_o are all low.
- R2: A start with M or N equal to zero or not a multiple of 16, or with K/8 or the tile count equal to zero, raises err_o for exactly the next cycle. busy_o stays low and no operand beat is accepted.
- R3: A and B beats are taken together, one pair per reduction step. Neither ready is high unless both valids are high and the core is in a reduction phase. A lone valid is not consumed.
- R4: Each block equals the signed product A(16xK)·B(Kx16), with K = 8·(K/8). A element (i,k) is at a_data_i bit (8i+k)·8, and B element (k,j) is at b_data_i bit (16k+j)·8. The accumulators restart from zero on every block.
- R5: A block leaves as 16 row beats, row 0 first. Element j of a row is at c_data_o bits [32j+31:32j]. c_last_o is high on row 15. c_data_o and c_last_o hold steady while c_valid_o is high and c_ready_i is low.
- R6: c_valid_o stays low while the reduction steps of a block are still being taken.
- R7: A job yields (M/16)·(N/16)·tiles blocks. done_o pulses once, in the cycle after the handshake of the last row, and busy_o drops with it.
- R8: Accumulation wraps modulo 2^32 with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a job with the current configuration |
| cfg_m_rows_i | input | 32 | M, rows of the output tile |
| cfg_n_cols_i | input | 32 | N, columns of one output tile |
| cfg_k_steps_i | input | 32 | K/8, reduction steps per block |
| cfg_n_tiles_i | input | 32 | N tiles handled per job |
| a_valid_i | input | 1 | A beat valid |
| a_ready_o | output | 1 | A beat taken |
| a_data_i | input | 1024 | 16x8 signed INT8 A slice |
| b_valid_i | input | 1 | B beat valid |
| b_ready_o | output | 1 | B beat taken |
| b_data_i | input | 1024 | 8x16 signed INT8 B slice |
| c_valid_o | output | 1 | Result row valid |
| c_ready_i | input | 1 | Result row accepted |
| c_data_o | output | 512 | 16 signed INT32 results of one row |
| c_last_o | output | 1 | Final row of a block |
| done_o | output | 1 | One-cycle end-of-job pulse |
| err_o | output | 1 | One-cycle configuration-refused pulse |
| busy_o | output | 1 | Job in progress |

## Verification
The bench runs a minimum 16x16x8 job and then a job of four blocks. If a design failed to clear its accumulators between blocks, the second block would carry the sums of the first. A run of 16400 steps with every operand at -128 pushes the sums past 2^31: a saturating design would pin them at the largest value instead of wrapping. Holding one valid alone catches a design that takes a half beat, which would shift every later sum by one step. Random backpressure on results catches rows that are dropped or changed while stalled. Four refused configurations check that a bad shape flags an error rather than starting a job.

// File: rtl/mm_pkg.sv
package mm_pkg;
   localparam int UNROLL = 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MAC   = 2'd1,
      ST_DRAIN = 2'd2
   } mm_state_e;
endpackage

// File: rtl/mm_mac_unit.sv
module mm_mac_unit #(
   parameter int SUB = 8,
   parameter int EW  = 8,
   parameter int AW  = 32,
   localparam int OPW = SUB * SUB * EW,
   localparam int ACW = SUB * SUB * AW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en_i,
   input  logic           first_i,
   input  logic [OPW-1:0] a_i,
   input  logic [OPW-1:0] b_i,
   output logic [ACW-1:0] acc_o
);
   logic signed [AW-1:0] prod [SUB*SUB];
   logic [AW-1:0] acc_q [SUB*SUB];

   always_comb begin
      for (int i = 0; i < SUB; i++) begin
         for (int j = 0; j < SUB; j++) begin
            logic signed [AW-1:0] sum;
            sum = '0;
            for (int k = 0; k < SUB; k++) begin
               logic signed [EW-1:0] ae;
               logic signed [EW-1:0] be;
               ae  = a_i[(i*SUB+k)*EW +: EW];
               be  = b_i[(k*SUB+j)*EW +: EW];
               sum = sum + AW'(ae) * AW'(be);
            end
            prod[i*SUB+j] = sum;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < SUB*SUB; e++) acc_q[e] <= '0;
      end else if (en_i) begin
         for (int e = 0; e < SUB*SUB; e++)
            acc_q[e] <= (first_i ? '0 : acc_q[e]) + prod[e];
      end
   end

   always_comb begin
      for (int e = 0; e < SUB*SUB; e++) acc_o[e*AW +: AW] = acc_q[e];
   end
endmodule

// File: rtl/mm_seq.sv
module mm_seq
   import mm_pkg::*;
#(
   parameter int SUB = 8,
   parameter int CW  = 32,
   localparam int BLK = UNROLL * SUB,
   localparam int RW  = $clog2(BLK),
   localparam int SH  = $clog2(BLK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [CW-1:0] cfg_m_i,
   input  logic [CW-1:0] cfg_n_i,
   input  logic [CW-1:0] cfg_k_i,
   input  logic [CW-1:0] cfg_t_i,
   input  logic          in_both_i,
   input  logic          c_ready_i,
   output logic          in_take_o,
   output logic          mac_first_o,
   output logic [RW-1:0] row_o,
   output logic          c_valid_o,
   output logic          c_last_o,
   output logic          done_o,
   output logic          err_o,
   output logic          busy_o
);
   mm_state_e     st_q;
   logic [CW-1:0] kcnt_q, klast_q, blk_q, blast_q;
   logic [RW-1:0] row_q;
   logic [CW-1:0] nblk;
   logic          bad_cfg;

   assign nblk = (cfg_m_i >> SH) * (cfg_n_i >> SH) * cfg_t_i;
   assign bad_cfg = (cfg_m_i == '0) || (cfg_m_i[SH-1:0] != '0) ||
                    (cfg_n_i == '0) || (cfg_n_i[SH-1:0] != '0) ||
                    (cfg_k_i == '0) || (cfg_t_i == '0);

   assign in_take_o   = (st_q == ST_MAC) && in_both_i;
   assign mac_first_o = (kcnt_q == '0);
   assign row_o       = row_q;
   assign c_valid_o   = (st_q == ST_DRAIN);
   assign c_last_o    = (st_q == ST_DRAIN) && (row_q == RW'(BLK-1));
   assign busy_o      = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         kcnt_q  <= '0;
         klast_q <= '0;
         blk_q   <= '0;
         blast_q <= '0;
         row_q   <= '0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (bad_cfg) begin
                     err_o <= 1'b1;
                  end else begin
                     st_q    <= ST_MAC;
                     kcnt_q  <= '0;
                     blk_q   <= '0;
                     klast_q <= cfg_k_i - 1'b1;
                     blast_q <= nblk - 1'b1;
                  end
               end
            end
            ST_MAC: begin
               if (in_take_o) begin
                  if (kcnt_q == klast_q) begin
                     st_q   <= ST_DRAIN;
                     row_q  <= '0;
                     kcnt_q <= '0;
                  end else begin
                     kcnt_q <= kcnt_q + 1'b1;
                  end
               end
            end
            ST_DRAIN: begin
               if (c_ready_i) begin
                  if (row_q == RW'(BLK-1)) begin
                     row_q <= '0;
                     if (blk_q == blast_q) begin
                        st_q   <= ST_IDLE;
                        done_o <= 1'b1;
                     end else begin
                        blk_q <= blk_q + 1'b1;
                        st_q  <= ST_MAC;
                     end
                  end else begin
                     row_q <= row_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mm_tile_core.sv
module mm_tile_core
   import mm_pkg::*;
#(
   parameter int SUB = 8,
   parameter int EW  = 8,
   parameter int AW  = 32,
   parameter int CW  = 32,
   localparam int BLK = UNROLL * SUB,
   localparam int RW  = $clog2(BLK),
   localparam int OPW = SUB * SUB * EW,
   localparam int ACW = SUB * SUB * AW,
   localparam int ABW = BLK * SUB * EW,
   localparam int CDW = BLK * AW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [CW-1:0]  cfg_m_rows_i,
   input  logic [CW-1:0]  cfg_n_cols_i,
   input  logic [CW-1:0]  cfg_k_steps_i,
   input  logic [CW-1:0]  cfg_n_tiles_i,
   input  logic           a_valid_i,
   output logic           a_ready_o,
   input  logic [ABW-1:0] a_data_i,
   input  logic           b_valid_i,
   output logic           b_ready_o,
   input  logic [ABW-1:0] b_data_i,
   output logic           c_valid_o,
   input  logic           c_ready_i,
   output logic [CDW-1:0] c_data_o,
   output logic           c_last_o,
   output logic           done_o,
   output logic           err_o,
   output logic           busy_o
);
   if (AW < 2*EW + $clog2(SUB)) begin : g_bad_aw
      $error("accumulator width too small for one sub-product");
   end
   if ((SUB & (SUB - 1)) != 0) begin : g_bad_sub
      $error("SUB must be a power of two");
   end

   logic          take, first;
   logic [RW-1:0] row;
   logic [ACW-1:0] acc_all [UNROLL*UNROLL];

   mm_seq #(.SUB(SUB), .CW(CW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .cfg_m_i    (cfg_m_rows_i),
      .cfg_n_i    (cfg_n_cols_i),
      .cfg_k_i    (cfg_k_steps_i),
      .cfg_t_i    (cfg_n_tiles_i),
      .in_both_i  (a_valid_i && b_valid_i),
      .c_ready_i  (c_ready_i),
      .in_take_o  (take),
      .mac_first_o(first),
      .row_o      (row),
      .c_valid_o  (c_valid_o),
      .c_last_o   (c_last_o),
      .done_o     (done_o),
      .err_o      (err_o),
      .busy_o     (busy_o)
   );

   assign a_ready_o = take;
   assign b_ready_o = take;

   for (genvar u = 0; u < UNROLL; u++) begin : g_row
      for (genvar v = 0; v < UNROLL; v++) begin : g_col
         logic [OPW-1:0] a_sl, b_sl;
         assign a_sl = a_data_i[u*OPW +: OPW];
         for (genvar k = 0; k < SUB; k++) begin : g_bk
            assign b_sl[k*SUB*EW +: SUB*EW] = b_data_i[(k*BLK + v*SUB)*EW +: SUB*EW];
         end
         mm_mac_unit #(.SUB(SUB), .EW(EW), .AW(AW)) u_mac (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (take),
            .first_i(first),
            .a_i    (a_sl),
            .b_i    (b_sl),
            .acc_o  (acc_all[u*UNROLL+v])
         );
      end
   end

   always_comb begin
      c_data_o = '0;
      for (int u = 0; u < UNROLL; u++) begin
         for (int i = 0; i < SUB; i++) begin
            if (row == RW'(u*SUB + i)) begin
               for (int v = 0; v < UNROLL; v++) begin
                  for (int j = 0; j < SUB; j++)
                     c_data_o[(v*SUB+j)*AW +: AW] = acc_all[u*UNROLL+v][(i*SUB+j)*AW +: AW];
               end
            end
         end
      end
   end
endmodule

// File: rtl/mm_tile_core_chk.sv
module mm_tile_core_chk #(
   parameter int CDW = 512
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start_i,
   input logic           a_ready_o,
   input logic           b_ready_o,
   input logic           c_valid_o,
   input logic           c_ready_i,
   input logic [CDW-1:0] c_data_o,
   input logic           c_last_o,
   input logic           done_o,
   input logic           err_o,
   input logic           busy_o
);
   AST_ERR_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(start_i) && !busy_o); // R2
   AST_ERR_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !a_ready_o && !b_ready_o); // R2
   AST_READY_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      a_ready_o == b_ready_o); // R3
   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      c_valid_o && !c_ready_i |=> c_valid_o && $stable(c_data_o) && $stable(c_last_o)); // R5
   AST_NO_ROW_IN_MAC: assert property (@(posedge clk) disable iff (!rst_n)
      a_ready_o |-> !c_valid_o); // R6
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(c_valid_o && c_ready_i && c_last_o) && !busy_o); // R7
endmodule

bind mm_tile_core mm_tile_core_chk #(.CDW(CDW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_ready_o(a_ready_o),
   .b_ready_o(b_ready_o), .c_valid_o(c_valid_o), .c_ready_i(c_ready_i),
   .c_data_o(c_data_o), .c_last_o(c_last_o), .done_o(done_o),
   .err_o(err_o), .busy_o(busy_o)
);

// File: tb/mm_tile_core_bench.sv
module mm_tile_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [31:0] cm = '0, cn = '0, ck = '0, ct = '0;
   logic a_valid = 1'b0, b_valid = 1'b0, c_ready = 1'b0;
   logic [1023:0] a_data = '0, b_data = '0;
   logic a_ready, b_ready, c_valid, c_last, done, err, busy;
   logic [511:0] c_data;

   int n_tests = 0, n_fail = 0, done_cnt = 0, rows_seen = 0, cycles = 0;
   bit bp_mode = 1'b0, finished = 1'b0;
   logic [511:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mm_tile_core u_mm_tile_core (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .cfg_m_rows_i(cm), .cfg_n_cols_i(cn), .cfg_k_steps_i(ck), .cfg_n_tiles_i(ct),
      .a_valid_i(a_valid), .a_ready_o(a_ready), .a_data_i(a_data),
      .b_valid_i(b_valid), .b_ready_o(b_ready), .b_data_i(b_data),
      .c_valid_o(c_valid), .c_ready_i(c_ready), .c_data_o(c_data), .c_last_o(c_last),
      .done_o(done), .err_o(err), .busy_o(busy)
   );

   task automatic check(bit ok, string req, string what, longint act, longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // monitor: pops expected rows as result rows are handed over
   always @(negedge clk) begin
      if (rst_n) begin
         c_ready <= bp_mode ? (($urandom % 3) != 0) : 1'b1;
         #1;
         if (done) done_cnt++;
         if (c_valid && c_ready) begin
            if (exp_q.size() == 0) begin
               check(0, "R4", "unexpected result row", rows_seen, -1);
            end else begin
               logic [511:0] e;
               e = exp_q.pop_front();
               n_tests++;
               if (c_data !== e) begin
                  n_fail++;
                  $display("FAIL R4/R8 row %0d: actual %h expected %h", rows_seen % 16, c_data, e);
               end
               check(c_last == ((rows_seen % 16) == 15), "R5", "c_last", c_last,
                     (rows_seen % 16) == 15);
            end
            rows_seen++;
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG && !finished) begin
            finished = 1'b1;
            check(0, "R7", "watchdog expired", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   task automatic start_job(int m, int n, int k, int t);
      @(negedge clk);
      cm = m; cn = n; ck = k; ct = t; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // mode 0: random signed operands, mode 1: every operand -128
   task automatic run_block(int ks, int mode, bit lone_valid, bit chk_gap);
      int expv [16][16];
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++) expv[i][j] = 0;
      for (int s = 0; s < ks; s++) begin
         logic signed [7:0] av [16][8];
         logic signed [7:0] bv [8][16];
         for (int i = 0; i < 16; i++)
            for (int k = 0; k < 8; k++) begin
               av[i][k] = (mode == 1) ? -8'sd128 : 8'($urandom);
               a_data[(i*8+k)*8 +: 8] = av[i][k];
            end
         for (int k = 0; k < 8; k++)
            for (int j = 0; j < 16; j++) begin
               bv[k][j] = (mode == 1) ? -8'sd128 : 8'($urandom);
               b_data[(k*16+j)*8 +: 8] = bv[k][j];
            end
         if (mode == 1) begin
            for (int i = 0; i < 16; i++)
               for (int j = 0; j < 16; j++) expv[i][j] += 131072;
         end else begin
            for (int i = 0; i < 16; i++)
               for (int j = 0; j < 16; j++)
                  for (int k = 0; k < 8; k++) expv[i][j] += int'(av[i][k]) * int'(bv[k][j]);
         end
         if (lone_valid && s == 0) begin
            a_valid = 1'b1; b_valid = 1'b0;
            for (int w = 0; w < 3; w++) begin
               #1;
               check(!a_ready && !b_ready, "R3", "ready with B invalid", a_ready, 0);
               @(negedge clk);
            end
            a_valid = 1'b0; b_valid = 1'b1;
            #1;
            check(!a_ready && !b_ready, "R3", "ready with A invalid", b_ready, 0);
            @(negedge clk);
         end
         if (mode == 0 && ($urandom % 4) == 0) begin
            a_valid = 1'b0; b_valid = 1'b0;
            @(negedge clk);
         end
         a_valid = 1'b1; b_valid = 1'b1;
         forever begin
            #1;
            if (a_ready && b_ready) break;
            @(negedge clk);
         end
         @(posedge clk);
         if (s == ks - 1) begin
            for (int i = 0; i < 16; i++) begin
               logic [511:0] r;
               for (int j = 0; j < 16; j++) r[j*32 +: 32] = expv[i][j];
               exp_q.push_back(r);
            end
         end
         @(negedge clk);
         a_valid = 1'b0; b_valid = 1'b0;
         if (chk_gap && s != ks - 1) begin
            #1;
            check(!c_valid, "R6", "row valid mid-reduction", c_valid, 0);
         end
      end
   endtask

   task automatic run_job(int m, int n, int k, int t, int mode, bit lone_valid);
      int d0, r0, nb;
      d0 = done_cnt; r0 = rows_seen;
      nb = (m / 16) * (n / 16) * t;
      start_job(m, n, k, t);
      #1;
      check(busy, "R7", "busy after start", busy, 1);
      for (int b = 0; b < nb; b++) run_block(k, mode, lone_valid && b == 0, mode == 0);
      while (busy) @(negedge clk);
      @(negedge clk); #2;
      check(done_cnt == d0 + 1, "R7", "done pulses", done_cnt - d0, 1);
      check(rows_seen - r0 == 16 * nb, "R7", "rows per job", rows_seen - r0, 16 * nb);
      check(exp_q.size() == 0, "R5", "rows left over", exp_q.size(), 0);
   endtask

   task automatic bad_cfg(int m, int n, int k, int t);
      int r0;
      r0 = rows_seen;
      a_valid = 1'b1; b_valid = 1'b1;
      start_job(m, n, k, t);
      #1;
      check(err, "R2", "err pulse", err, 1);
      check(!busy, "R2", "busy after refusal", busy, 0);
      check(!a_ready && !b_ready, "R2", "operand taken", a_ready, 0);
      @(negedge clk); #1;
      check(!err, "R2", "err width", err, 0);
      check(rows_seen == r0 && !c_valid, "R2", "output after refusal", c_valid, 0);
      a_valid = 1'b0; b_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(!busy && !done && !err && !c_valid && !a_ready && !b_ready, "R1",
            "outputs during reset", {busy, done, err, c_valid, a_ready, b_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(!busy && !c_valid && !a_ready, "R1", "outputs after reset", busy, 0);

      run_job(16, 16, 1, 1, 0, 1'b0);          // R4 minimum tile
      bp_mode = 1'b1;
      run_job(32, 16, 4, 2, 0, 1'b1);          // R4 R3 R5 four blocks, backpressure
      run_job(16, 32, 3, 1, 0, 1'b0);          // R4 two blocks along N
      bp_mode = 1'b0;
      run_job(16, 16, 16400, 1, 1, 1'b0);      // R8 wrap past 2^31

      bad_cfg(24, 16, 1, 1);                   // R2 M not multiple of 16
      bad_cfg(16, 8, 1, 1);                    // R2 N not multiple of 16
      bad_cfg(16, 16, 0, 1);                   // R2 zero reduction steps
      bad_cfg(16, 16, 2, 0);                   // R2 zero tiles

      run_job(16, 16, 2, 1, 0, 1'b0);          // R2 core still usable after refusals

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule